// File: doc/BRIEF.md
# Paged Ethernet Controller Register Bank

This block is the byte-wide host register window of a simple Ethernet controller. A host reaches it through a 4-bit port offset. A 2-bit page field, stored in the top two bits of the command register, selects which of several register sets that offset refers to. The bank stores the receive ring limits and boundary, the transmit page and length, the remote DMA address and length, and the data configuration byte. It also stores the interrupt status and interrupt mask, the six-byte station address, the current receive page and the eight-byte multicast filter.

Other controller blocks report events through a status-set input vector. Transmit starts go out to the transmit engine as a one-cycle request. That request carries the frame's byte address and length. One level interrupt line is high while any unmasked status bit is set.

A start command completes two cases at once. A remote DMA command with a zero byte count finishes immediately. A transmit command is accepted immediately and its status is reported straight away.

Top module: `nic_regfile`

## Requirements
- R1: Port offset 0 writes and reads the command byte on every page (page = command bits [7:6]).
- R2: Other offsets decode as {page, offset}. On page 0: offset 3 is the boundary (read/write), offset 4 reads transmit status, offset 7 is interrupt status, and offsets 8/9 are the remote address low/high (read/write). On page 1: offsets 1–6 are the station address bytes, offset 7 is the current page, and offsets 8–15 are the multicast bytes, all readable back.
- R3: Reads of any offset not listed in R2 return 0x00, including page 0 write-only offsets and all of pages 2 and 3. Writes on pages 2 and 3 change nothing.
- R4: Writing interrupt status (page 0, offset 7) clears each of bits [6:0] written as 1. Bit 7 (reset done) is never cleared by this write.
- R5: A command write with bit 1 (start) set clears status bit 7.
- R6: A start command that also has bit 3 or bit 4 set (remote read/write) sets status bit 6 when the remote byte count is 0, and leaves bit 6 alone otherwise.
- R7: A start command with bit 2 set pulses `tx_req_o` for exactly one cycle, in the cycle after the write. In that cycle `tx_addr_o` = {transmit page, 0x00} and `tx_len_o` = the transmit length. Transmit status becomes 0x01 and status bit 1 is set. Bit 2 without the start bit does nothing.
- R8: `irq_o` is high exactly when (status AND mask) is nonzero, and follows a status or mask change in the cycle after it.
- R9: On page 0, offset 1 sets `ring_start_o` to value<<8 and offset 2 sets `ring_stop_o` to value<<8. Offsets 4, 5/6, 10/11 and 14 load the transmit page, the transmit length (low/high), the remote count (low/high) and `data_cfg_o`.
- R10: After reset, status reads 0x80, every other register is 0, and `irq_o` and `tx_req_o` are low.
- R11: Each bit of `status_set_i` sets status bit [i] in the next cycle. Setting a bit takes priority over clearing it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| addr_i | input | 4 | Port offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| status_set_i | input | 7 | Event inputs setting status bits [6:0] |
| irq_o | output | 1 | Level interrupt |
| tx_req_o | output | 1 | One-cycle transmit request |
| tx_addr_o | output | 16 | Transmit frame byte address |
| tx_len_o | output | 16 | Transmit frame length |
| ring_start_o | output | 16 | Receive ring start byte address |
| ring_stop_o | output | 16 | Receive ring end byte address |
| rdma_cnt_o | output | 16 | Remote DMA byte count |
| data_cfg_o | output | 8 | Data configuration byte |

## Verification
The same offsets are written and read back on each of the four pages. This separates page 1 storage from page 0 registers that share its offsets, and shows that pages 2 and 3 are empty. Start commands are tried with remote read, remote write and transmit bits set with and without the start bit, and with both zero and nonzero remote counts. This separates the immediate-completion paths from commands that must do nothing. Status clearing uses patterns that include bit 7 and is also done in the same cycle as an event set. These checks show the protected bit and the set-over-clear priority.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
  localparam int DW   = 8;
  localparam int AW   = 4;
  localparam int PW   = 2;
  localparam int IDXW = AW + PW;

  // command bits
  localparam int CMD_GO  = 1;
  localparam int CMD_TX  = 2;
  localparam int CMD_RRD = 3;
  localparam int CMD_RWR = 4;

  // status bits
  localparam int ST_TXOK = 1;
  localparam int ST_RDMA = 6;
  localparam int ST_BOOT = 7;

  // {page, offset} register indices
  localparam logic [IDXW-1:0] IX_RING_LO = 6'h01;
  localparam logic [IDXW-1:0] IX_RING_HI = 6'h02;
  localparam logic [IDXW-1:0] IX_BNDRY   = 6'h03;
  localparam logic [IDXW-1:0] IX_TXPG    = 6'h04;
  localparam logic [IDXW-1:0] IX_TXLEN_L = 6'h05;
  localparam logic [IDXW-1:0] IX_TXLEN_H = 6'h06;
  localparam logic [IDXW-1:0] IX_STAT    = 6'h07;
  localparam logic [IDXW-1:0] IX_RADR_L  = 6'h08;
  localparam logic [IDXW-1:0] IX_RADR_H  = 6'h09;
  localparam logic [IDXW-1:0] IX_RCNT_L  = 6'h0A;
  localparam logic [IDXW-1:0] IX_RCNT_H  = 6'h0B;
  localparam logic [IDXW-1:0] IX_DCFG    = 6'h0E;
  localparam logic [IDXW-1:0] IX_MASK    = 6'h0F;
  localparam logic [IDXW-1:0] IX_STN     = 6'h11;
  localparam logic [IDXW-1:0] IX_CURPG   = 6'h17;
  localparam logic [IDXW-1:0] IX_MCAST   = 6'h18;
endpackage

// File: rtl/nic_page_decode.sv
module nic_page_decode #(
  parameter int ADDR_W = 4,
  parameter int PAGE_W = 2,
  localparam int IDX_W = ADDR_W + PAGE_W
) (
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              is_cmd_o,
  output logic              wr_cmd_o,
  output logic              wr_reg_o
);
  assign is_cmd_o = (addr_i == '0);
  assign idx_o    = {page_i, addr_i};
  assign wr_cmd_o = wr_en_i & is_cmd_o;
  assign wr_reg_o = wr_en_i & ~is_cmd_o;
endmodule

// File: rtl/nic_byte_bank.sv
module nic_byte_bank #(
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 6,
  parameter int N_BYTES = 6,
  parameter logic [IDX_W-1:0] BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [IDX_W-1:0] NUM = IDX_W'(N_BYTES);

  logic [IDX_W-1:0]  sel;
  logic [DATA_W-1:0] mem_q [N_BYTES];

  assign sel   = idx_i - BASE;
  assign hit_o = (idx_i >= BASE) && (sel < NUM);

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (wr_i && hit_o && sel == IDX_W'(g))    mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_BYTES; i++)
      if (sel == IDX_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_wr_i,
  input  logic [DATA_W-1:0] clr_val_i,
  input  logic              boot_clr_i,
  input  logic [DATA_W-1:0] set_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_val_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] stat_q, stat_d, mask_q;

  always_comb begin
    stat_d = stat_q;
    if (clr_wr_i) stat_d[DATA_W-2:0] = stat_q[DATA_W-2:0] & ~clr_val_i[DATA_W-2:0];
    if (boot_clr_i) stat_d[DATA_W-1] = 1'b0;
    stat_d = stat_d | set_i;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= DATA_W'(1) << (DATA_W - 1);
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_wr_i) mask_q <= mask_val_i;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_q);
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_reg_pkg::*;
#(
  parameter int DATA_W      = DW,
  parameter int ADDR_W      = AW,
  parameter int PAGE_W      = PW,
  parameter int STN_BYTES   = 6,
  parameter int MCAST_BYTES = 8,
  localparam int IDX_W = ADDR_W + PAGE_W,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-2:0] status_set_i,
  output logic              irq_o,
  output logic              tx_req_o,
  output logic [CNT_W-1:0]  tx_addr_o,
  output logic [CNT_W-1:0]  tx_len_o,
  output logic [CNT_W-1:0]  ring_start_o,
  output logic [CNT_W-1:0]  ring_stop_o,
  output logic [CNT_W-1:0]  rdma_cnt_o,
  output logic [DATA_W-1:0] data_cfg_o
);
  logic [DATA_W-1:0] cmd_q, ring_lo_q, ring_hi_q, bndry_q, txpg_q, tsr_q, dcfg_q, curpg_q;
  logic [CNT_W-1:0]  txlen_q, radr_q, rcnt_q;
  logic              tx_req_q;

  logic [IDX_W-1:0]  idx;
  logic              is_cmd, wr_cmd, wr_reg;
  logic              go, go_tx, go_zero_dma;
  logic [DATA_W-1:0] set_vec, isr_q;
  logic              stn_hit, mc_hit;
  logic [DATA_W-1:0] stn_rd, mc_rd;

  nic_page_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dec (
    .wr_en_i (wr_en_i),
    .page_i  (cmd_q[DATA_W-1 -: PAGE_W]),
    .addr_i  (addr_i),
    .idx_o   (idx),
    .is_cmd_o(is_cmd),
    .wr_cmd_o(wr_cmd),
    .wr_reg_o(wr_reg)
  );

  assign go          = wr_cmd & wdata_i[CMD_GO];
  assign go_tx       = go & wdata_i[CMD_TX];
  assign go_zero_dma = go & (wdata_i[CMD_RRD] | wdata_i[CMD_RWR]) & (rcnt_q == '0);

  always_comb begin
    set_vec          = {1'b0, status_set_i};
    set_vec[ST_TXOK] = set_vec[ST_TXOK] | go_tx;
    set_vec[ST_RDMA] = set_vec[ST_RDMA] | go_zero_dma;
  end

  nic_irq_unit #(.DATA_W(DATA_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_wr_i  (wr_reg && idx == IX_STAT),
    .clr_val_i (wdata_i),
    .boot_clr_i(go),
    .set_i     (set_vec),
    .mask_wr_i (wr_reg && idx == IX_MASK),
    .mask_val_i(wdata_i),
    .stat_o    (isr_q),
    .irq_o     (irq_o)
  );

  nic_byte_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_BYTES(STN_BYTES), .BASE(IX_STN)) u_stn (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_reg), .idx_i(idx),
    .wdata_i(wdata_i), .hit_o(stn_hit), .rdata_o(stn_rd)
  );

  nic_byte_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .N_BYTES(MCAST_BYTES), .BASE(IX_MCAST)) u_mc (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_reg), .idx_i(idx),
    .wdata_i(wdata_i), .hit_o(mc_hit), .rdata_o(mc_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0; ring_lo_q <= '0; ring_hi_q <= '0; bndry_q <= '0;
      txpg_q <= '0; tsr_q <= '0; dcfg_q <= '0; curpg_q <= '0;
      txlen_q <= '0; radr_q <= '0; rcnt_q <= '0; tx_req_q <= 1'b0;
    end else begin
      tx_req_q <= go_tx;
      if (go_tx) tsr_q <= DATA_W'(1);
      if (wr_cmd) cmd_q <= wdata_i;
      if (wr_reg) begin
        unique case (idx)
          IX_RING_LO: ring_lo_q <= wdata_i;
          IX_RING_HI: ring_hi_q <= wdata_i;
          IX_BNDRY:   bndry_q   <= wdata_i;
          IX_TXPG:    txpg_q    <= wdata_i;
          IX_TXLEN_L: txlen_q[DATA_W-1:0]      <= wdata_i;
          IX_TXLEN_H: txlen_q[CNT_W-1:DATA_W]  <= wdata_i;
          IX_RADR_L:  radr_q[DATA_W-1:0]       <= wdata_i;
          IX_RADR_H:  radr_q[CNT_W-1:DATA_W]   <= wdata_i;
          IX_RCNT_L:  rcnt_q[DATA_W-1:0]       <= wdata_i;
          IX_RCNT_H:  rcnt_q[CNT_W-1:DATA_W]   <= wdata_i;
          IX_DCFG:    dcfg_q    <= wdata_i;
          IX_CURPG:   curpg_q   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_cmd)       rdata_o = cmd_q;
    else if (stn_hit) rdata_o = stn_rd;
    else if (mc_hit)  rdata_o = mc_rd;
    else begin
      case (idx)
        IX_BNDRY:  rdata_o = bndry_q;
        IX_TXPG:   rdata_o = tsr_q;
        IX_STAT:   rdata_o = isr_q;
        IX_RADR_L: rdata_o = radr_q[DATA_W-1:0];
        IX_RADR_H: rdata_o = radr_q[CNT_W-1:DATA_W];
        IX_CURPG:  rdata_o = curpg_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign tx_req_o     = tx_req_q;
  assign tx_addr_o    = {txpg_q, DATA_W'(0)};
  assign tx_len_o     = txlen_q;
  assign ring_start_o = {ring_lo_q, DATA_W'(0)};
  assign ring_stop_o  = {ring_hi_q, DATA_W'(0)};
  assign rdma_cnt_o   = rcnt_q;
  assign data_cfg_o   = dcfg_q;
endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk
  import nic_reg_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-2:0] status_set_i,
  input logic          irq_o,
  input logic          tx_req_o,
  input logic [2*DW-1:0] rdma_cnt_o,
  input logic [DW-1:0] isr_i
);
  logic go_w;
  assign go_w = wr_en_i && (addr_i == '0) && wdata_i[CMD_GO];

  p_boot_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_w |=> $stable(isr_i[ST_BOOT]));

  p_boot_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_w |=> !isr_i[ST_BOOT]);

  p_zero_dma_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_w && (wdata_i[CMD_RRD] || wdata_i[CMD_RWR]) && rdma_cnt_o == '0) |=> isr_i[ST_RDMA]);

  p_tx_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_w && wdata_i[CMD_TX]) |=> (tx_req_o && isr_i[ST_TXOK]));

  p_tx_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);

  p_tx_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(go_w && wdata_i[CMD_TX]) |=> !tx_req_o);

  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (isr_i != '0));

  p_evt_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_set_i != '0) |=> ((isr_i[DW-2:0] & $past(status_set_i)) == $past(status_set_i)));
endmodule

bind nic_regfile nic_regfile_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .status_set_i(status_set_i),
  .irq_o       (irq_o),
  .tx_req_o    (tx_req_o),
  .rdma_cnt_o  (rdma_cnt_o),
  .isr_i       (isr_q)
);

// File: tb/nic_regfile_bench.sv
module nic_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 39;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [6:0]  sset = '0;
  logic [7:0]  rdata, data_cfg;
  logic        irq, tx_req;
  logic [15:0] tx_addr, tx_len, ring_start, ring_stop, rdma_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_regfile u_nic_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .status_set_i(sset), .irq_o(irq), .tx_req_o(tx_req),
    .tx_addr_o(tx_addr), .tx_len_o(tx_len), .ring_start_o(ring_start),
    .ring_stop_o(ring_stop), .rdma_cnt_o(rdma_cnt), .data_cfg_o(data_cfg)
  );

  // {is_read, offset, wdata, expected, requirement}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'h4, 8'h00, 8'h00, 4'd10},  // R10 transmit status after reset
    {1'b0, 4'h0, 8'h40, 8'h00, 4'd1},   // page 1
    {1'b0, 4'h1, 8'h11, 8'h00, 4'd2},
    {1'b0, 4'h2, 8'h22, 8'h00, 4'd2},
    {1'b0, 4'h3, 8'h33, 8'h00, 4'd2},
    {1'b0, 4'h4, 8'h44, 8'h00, 4'd2},
    {1'b0, 4'h5, 8'h55, 8'h00, 4'd2},
    {1'b0, 4'h6, 8'h66, 8'h00, 4'd2},
    {1'b0, 4'h7, 8'h4C, 8'h00, 4'd2},
    {1'b0, 4'h8, 8'h81, 8'h00, 4'd2},
    {1'b0, 4'hF, 8'h8F, 8'h00, 4'd2},
    {1'b1, 4'h1, 8'h00, 8'h11, 4'd2},   // R2 station bytes
    {1'b1, 4'h3, 8'h00, 8'h33, 4'd2},
    {1'b1, 4'h6, 8'h00, 8'h66, 4'd2},
    {1'b1, 4'h7, 8'h00, 8'h4C, 4'd2},   // current page
    {1'b1, 4'h8, 8'h00, 8'h81, 4'd2},   // multicast
    {1'b1, 4'hF, 8'h00, 8'h8F, 4'd2},
    {1'b1, 4'h0, 8'h00, 8'h40, 4'd1},   // R1 command on page 1
    {1'b0, 4'h0, 8'h00, 8'h00, 4'd1},   // page 0
    {1'b1, 4'h3, 8'h00, 8'h00, 4'd2},   // boundary untouched by page 1
    {1'b0, 4'h3, 8'h2A, 8'h00, 4'd2},
    {1'b1, 4'h3, 8'h00, 8'h2A, 4'd2},
    {1'b1, 4'h1, 8'h00, 8'h00, 4'd3},   // R3 write-only offset reads 0
    {1'b1, 4'h7, 8'h00, 8'h80, 4'd2},
    {1'b0, 4'h8, 8'h34, 8'h00, 4'd2},
    {1'b0, 4'h9, 8'h12, 8'h00, 4'd2},
    {1'b1, 4'h8, 8'h00, 8'h34, 4'd2},
    {1'b1, 4'h9, 8'h00, 8'h12, 4'd2},
    {1'b0, 4'h0, 8'h80, 8'h00, 4'd1},   // page 2
    {1'b1, 4'h1, 8'h00, 8'h00, 4'd3},
    {1'b1, 4'h3, 8'h00, 8'h00, 4'd3},
    {1'b1, 4'hF, 8'h00, 8'h00, 4'd3},
    {1'b0, 4'h3, 8'hFF, 8'h00, 4'd3},
    {1'b1, 4'h0, 8'h00, 8'h80, 4'd1},
    {1'b0, 4'h0, 8'hC0, 8'h00, 4'd1},   // page 3
    {1'b1, 4'h7, 8'h00, 8'h00, 4'd3},
    {1'b1, 4'h0, 8'h00, 8'hC0, 4'd1},
    {1'b0, 4'h0, 8'h00, 8'h00, 4'd1},
    {1'b1, 4'h3, 8'h00, 8'h2A, 4'd3}    // R3 page-2 write ignored
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1 check({8'h00, rdata}, {8'h00, exp}, req);
  endtask

  task automatic pulse_set(input logic [6:0] v);
    @(negedge clk);
    sset = v;
    @(negedge clk);
    sset = '0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    rd(4'h7, 8'h80, "R10");
    check({15'd0, irq}, 16'd0, "R10");
    check({15'd0, tx_req}, 16'd0, "R10");
    check(ring_start, 16'h0000, "R10");
    check(rdma_cnt, 16'h0000, "R10");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24])
        rd(VEC[i][23:20], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
      else
        wr(VEC[i][23:20], VEC[i][19:12]);
    end

    // R9 page-0 loads; page-1/2 writes to the same offsets left them alone
    check(ring_start, 16'h0000, "R3");
    wr(4'h1, 8'h40); wr(4'h2, 8'h80);
    wr(4'hA, 8'h05); wr(4'hB, 8'h01);
    wr(4'h5, 8'h3C); wr(4'h6, 8'h00);
    wr(4'h4, 8'h20); wr(4'hE, 8'h49);
    check(ring_start, 16'h4000, "R9");
    check(ring_stop, 16'h8000, "R9");
    check(rdma_cnt, 16'h0105, "R9");
    check(tx_len, 16'h003C, "R9");
    check(tx_addr, 16'h2000, "R9");
    check({8'h00, data_cfg}, 16'h0049, "R9");

    // R11 / R4 event set and write-one clear
    pulse_set(7'h7F);
    rd(4'h7, 8'hFF, "R11");
    wr(4'h7, 8'hFF);
    rd(4'h7, 8'h80, "R4");
    pulse_set(7'h03);
    wr(4'h7, 8'h01);
    rd(4'h7, 8'h82, "R4");

    // R8 interrupt follows status and mask
    check({15'd0, irq}, 16'd0, "R8");
    wr(4'hF, 8'h02);
    check({15'd0, irq}, 16'd1, "R8");
    wr(4'h7, 8'h02);
    check({15'd0, irq}, 16'd0, "R8");
    wr(4'hF, 8'h80);
    check({15'd0, irq}, 16'd1, "R8");

    // R5 start clears reset-done
    wr(4'h0, 8'h02);
    rd(4'h7, 8'h00, "R5");
    check({15'd0, irq}, 16'd0, "R5");

    // R6 zero-length remote DMA
    wr(4'h0, 8'h0A);
    rd(4'h7, 8'h00, "R6");
    wr(4'hA, 8'h00); wr(4'hB, 8'h00);
    wr(4'h0, 8'h0A);
    rd(4'h7, 8'h40, "R6");
    wr(4'h7, 8'h40);
    wr(4'h0, 8'h12);
    rd(4'h7, 8'h40, "R6");
    wr(4'h7, 8'h40);
    wr(4'h0, 8'h08);
    rd(4'h7, 8'h00, "R6");

    // R7 transmit start
    wr(4'h0, 8'h06);
    check({15'd0, tx_req}, 16'd1, "R7");
    check(tx_addr, 16'h2000, "R7");
    check(tx_len, 16'h003C, "R7");
    @(negedge clk);
    check({15'd0, tx_req}, 16'd0, "R7");
    rd(4'h4, 8'h01, "R7");
    rd(4'h7, 8'h02, "R7");
    wr(4'h7, 8'h02);
    wr(4'h0, 8'h04);
    check({15'd0, tx_req}, 16'd0, "R7");
    rd(4'h7, 8'h00, "R7");

    // R11 set wins over simultaneous clear
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h7; wdata = 8'h01; sset = 7'h01;
    @(negedge clk);
    wr_en = 1'b0; sset = '0;
    rd(4'h7, 8'h01, "R11");

    summary();
  end
endmodule